// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is a bus master for one chip-select region whose peripherals share one set of pins for address and data. An internal requester presents an address, write data, a read/write flag and byte enables. The controller then runs a complete bus cycle: the address goes out on the shared lines for a fixed three-cycle phase, marked by an active-low address-hold strobe. Two data cycles follow, in which the read strobe or the per-lane write strobes are active. Read data and a one-cycle completion pulse come back to the requester.

The width of each access comes from the request itself. When bit 14 of the request address is 1, the access uses all sixteen shared lines. When it is 0, the access uses only the low eight, and the upper lines stay undriven. A mode-enable input, which a control register drives elsewhere, turns on the multiplexed form. While it is low, a request is answered at once with an error completion and the pins stay quiet. The shared lines are brought out as separate output, output-enable (one per byte lane) and input vectors, and the pad ring joins them into one bidirectional bus.

Top module: `muxbus_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, cs_n, adr_hold_n, rd_n and every wr_n bit are 1, every bus_oe bit is 0, and rsp_done and rsp_err are 0. Asserting rst_n in the middle of an access returns the pins to this state at once.
- R2: With mux_en at 1, a request that req_valid presents while the controller is idle is accepted on that clock edge. cs_n is 0 for exactly five cycles, starting in the cycle after acceptance.
- R3: The first three cycles with cs_n at 0 form the address phase. adr_hold_n is 0 in exactly these three cycles, and rd_n and all wr_n bits stay 1.
- R4: During the address phase, bus_oe[0] is 1 and bus_out[7:0] carries address bits 7:0. When address bit 14 is 1, bus_oe[1] is also 1 and bus_out[15:8] carries address bits 15:8. When address bit 14 is 0, bus_oe[1] is 0.
- R5: On a read, both bus_oe bits are 0 and rd_n is 0 in the two data cycles. bus_in is sampled at the end of the second data cycle. rsp_rdata becomes bus_in for a 16-bit access, and {8'h00, bus_in[7:0]} for an 8-bit access.
- R6: On a 16-bit write, bus_out carries the write data and both bus_oe bits are 1 during both data cycles. wr_n[i] is 0 in those cycles exactly when req_be[i] is 1. Lane 0 is bus lines 7:0 and lane 1 is lines 15:8.
- R7: On an 8-bit write, write data bits 7:0 go out on bus lines 7:0. wr_n[1] and bus_oe[1] stay 1 and 0. wr_n[0] asserts only when req_be[0] is 1, and req_be[1] has no effect.
- R8: rsp_done is 1 for exactly the one cycle after the second data cycle, with rsp_err at 0, cs_n at 1 and rsp_rdata already valid for a read.
- R9: With mux_en at 0, a request made while idle produces rsp_done and rsp_err at 1 in the next cycle, with no chip select and no strobe activity.
- R10: A request presented while an access is in progress is not accepted or queued. No chip select follows the completion of the running access.
- R11: A request presented in the completion cycle is accepted, and its address phase begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mux_en | input | 1 | Multiplexed mode enable, from a control register bit |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 16 | Access address; bit 14 selects 16-bit width |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables per lane |
| rsp_rdata | output | 16 | Read data, held until the next read completes |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| cs_n | output | 1 | Active-low chip select |
| adr_hold_n | output | 1 | Active-low address-hold strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 2 | Active-low write strobes per byte lane |
| bus_out | output | 16 | Shared bus output value |
| bus_oe | output | 2 | Output enable per byte lane |
| bus_in | input | 16 | Shared bus input value |

## Verification
The completion pulse of one access and the acceptance of the next request can fall in the same cycle. The stimulus table is walked with no idle cycles, so every new request is raised exactly in the previous access's completion cycle. For each entry, the bench checks that the completion flags and read data of the old access are correct in that cycle, and that the new address appears on the pins in the following cycle. One entry also drops mux_en in a completion cycle, so the refusal path has to fire right after a finished access.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  // Sequencer states: idle, three address cycles, two data cycles.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADR1 = 3'd1,
    ST_ADR2 = 3'd2,
    ST_ADR3 = 3'd3,
    ST_DAT1 = 3'd4,
    ST_DAT2 = 3'd5
  } mx_state_e;

endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mux_en,
  input  logic req_valid,
  output logic accept,
  output logic cs_act,
  output logic addr_ph,
  output logic data_ph,
  output logic last_data,
  output logic done,
  output logic err
);

  mx_state_e st_q, st_d;
  logic      refuse;
  logic      done_q, done_d;
  logic      err_q, err_d;

  always_comb begin
    accept = (st_q == ST_IDLE) && req_valid && mux_en;
    refuse = (st_q == ST_IDLE) && req_valid && !mux_en;
    st_d   = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_ADR1;
      ST_ADR1: st_d = ST_ADR2;
      ST_ADR2: st_d = ST_ADR3;
      ST_ADR3: st_d = ST_DAT1;
      ST_DAT1: st_d = ST_DAT2;
      ST_DAT2: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    done_d = (st_q == ST_DAT2) || refuse;
    err_d  = refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    cs_act    = (st_q != ST_IDLE);
    addr_ph   = (st_q == ST_ADR1) || (st_q == ST_ADR2) || (st_q == ST_ADR3);
    data_ph   = (st_q == ST_DAT1) || (st_q == ST_DAT2);
    last_data = (st_q == ST_DAT2);
    done      = done_q;
    err       = err_q;
  end

endmodule

// File: rtl/muxbus_lane.sv
module muxbus_lane #(
  parameter int LANE_IDX = 0
) (
  input  logic       addr_ph,
  input  logic       data_ph,
  input  logic       is_write,
  input  logic       wide,
  input  logic       be_bit,
  input  logic [7:0] addr_byte,
  input  logic [7:0] wdata_byte,
  output logic [7:0] out_byte,
  output logic       oe,
  output logic       wr_n
);

  // Lane 0 carries every access; higher lanes only 16-bit ones.
  logic lane_on;

  always_comb begin
    lane_on  = (LANE_IDX == 0) || wide;
    oe       = lane_on && (addr_ph || (data_ph && is_write));
    out_byte = addr_ph ? addr_byte : wdata_byte;
    wr_n     = !(lane_on && data_ph && is_write && be_bit);
  end

endmodule

// File: rtl/muxbus_rdcap.sv
module muxbus_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              wide,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (cap_en) begin
      if (wide) rdata_d = bus_in;
      else      rdata_d = {{(DATA_W-8){1'b0}}, bus_in[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WSEL_BIT = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mux_en,
  input  logic                  req_valid,
  input  logic [DATA_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  req_write,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_done,
  output logic                  rsp_err,
  output logic                  cs_n,
  output logic                  adr_hold_n,
  output logic                  rd_n,
  output logic [DATA_W/8-1:0]   wr_n,
  output logic [DATA_W-1:0]     bus_out,
  output logic [DATA_W/8-1:0]   bus_oe,
  input  logic [DATA_W-1:0]     bus_in
);

  localparam int LANES = DATA_W / 8;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic accept, cs_act, addr_ph, data_ph, last_data;

  muxbus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mux_en    (mux_en),
    .req_valid (req_valid),
    .accept    (accept),
    .cs_act    (cs_act),
    .addr_ph   (addr_ph),
    .data_ph   (data_ph),
    .last_data (last_data),
    .done      (rsp_done),
    .err       (rsp_err)
  );

  // Request capture, loaded on acceptance.
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [LANES-1:0]  be_q, be_d;
  logic              write_q, write_d;
  logic              wide_q, wide_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    be_d    = be_q;
    write_d = write_q;
    wide_d  = wide_q;
    if (accept) begin
      addr_d  = req_addr;
      wdata_d = req_wdata;
      be_d    = req_be;
      write_d = req_write;
      wide_d  = req_addr[WSEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
      write_q <= write_d;
      wide_q  <= wide_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    muxbus_lane #(.LANE_IDX(g)) u_lane (
      .addr_ph    (addr_ph),
      .data_ph    (data_ph),
      .is_write   (write_q),
      .wide       (wide_q),
      .be_bit     (be_q[g]),
      .addr_byte  (addr_q[8*g +: 8]),
      .wdata_byte (wdata_q[8*g +: 8]),
      .out_byte   (bus_out[8*g +: 8]),
      .oe         (bus_oe[g]),
      .wr_n       (wr_n[g])
    );
  end

  muxbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (last_data && !write_q),
    .wide   (wide_q),
    .bus_in (bus_in),
    .rdata  (rsp_rdata)
  );

  always_comb begin
    cs_n       = !cs_act;
    adr_hold_n = !addr_ph;
    rd_n       = !(data_ph && !write_q);
  end

endmodule

// File: rtl/muxbus_ctrl_chk.sv
module muxbus_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             adr_hold_n,
  input logic             rd_n,
  input logic [LANES-1:0] wr_n,
  input logic [LANES-1:0] bus_oe,
  input logic             done,
  input logic             err,
  input logic             wide
);

  // R3: address strobe only inside a chip-select window, never with data strobes
  p_hold_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_hold_n |-> (!cs_n && rd_n && (&wr_n)));

  // R3: address phase lasts exactly three cycles
  p_hold_three_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adr_hold_n) |=> !adr_hold_n ##1 !adr_hold_n ##1 adr_hold_n);

  // R2: two data cycles follow the address phase, then chip select drops
  p_cs_after_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adr_hold_n) && !cs_n) |-> !cs_n ##1 !cs_n ##1 cs_n);

  // R5: read strobe only with the bus released
  p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!cs_n && adr_hold_n && bus_oe == '0 && (&wr_n)));

  // R7: upper lanes silent in 8-bit accesses
  p_narrow_upper_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (bus_oe[LANES-1:1] == '0 && (&wr_n[LANES-1:1])));

  // R8: completion cycle has no chip select
  p_done_bus_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R9: error always comes with done, after an idle cycle
  p_err_no_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && $past(cs_n)));

endmodule

bind muxbus_ctrl muxbus_ctrl_chk #(.LANES(DATA_W/8)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .adr_hold_n (adr_hold_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .bus_oe     (bus_oe),
  .done       (rsp_done),
  .err        (rsp_err),
  .wide       (wide_q)
);

// File: tb/muxbus_ctrl_bench.sv
module muxbus_ctrl_bench;

  typedef struct packed {
    logic        en;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [1:0]  be;
    logic [15:0] din;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 16'h4ABC, 16'h0000, 2'b11, 16'hBEEF, 16'hBEEF},
    '{1'b1, 1'b0, 16'h3456, 16'h0000, 2'b11, 16'hA55A, 16'h005A},
    '{1'b1, 1'b1, 16'h7F00, 16'h1234, 2'b11, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 16'h4002, 16'hCAFE, 2'b10, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 16'h0081, 16'h99C3, 2'b11, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 16'h00FF, 16'h5A5A, 2'b10, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 16'h4000, 16'h0000, 2'b11, 16'h1111, 16'h0000},
    '{1'b1, 1'b0, 16'hC0DE, 16'h0000, 2'b01, 16'h0F0F, 16'h0F0F}
  };

  logic        clk;
  logic        rst_n;
  logic        mux_en;
  logic        req_valid;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_write;
  logic [1:0]  req_be;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic        rsp_err;
  logic        cs_n;
  logic        adr_hold_n;
  logic        rd_n;
  logic [1:0]  wr_n;
  logic [15:0] bus_out;
  logic [1:0]  bus_oe;
  logic [15:0] bus_in;

  int n_chk;
  int n_fail;

  muxbus_ctrl u_muxbus_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mux_en     (mux_en),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_write  (req_write),
    .req_be     (req_be),
    .rsp_rdata  (rsp_rdata),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .cs_n       (cs_n),
    .adr_hold_n (adr_hold_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .bus_in     (bus_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_pins(string tag);
    check(tag, {26'd0, cs_n, adr_hold_n, rd_n, wr_n, bus_oe != 2'b00},
               {26'd0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
  endtask

  // Presents a request at the current falling edge and follows it to its
  // completion cycle; returns at that falling edge without idling.
  task automatic run(vec_t v, bit poke);
    logic        wide;
    logic [1:0]  wexp;
    logic [15:0] amask;
    logic [15:0] dmask;
    wide  = v.addr[14];
    amask = wide ? 16'hFFFF : 16'h00FF;
    wexp  = !v.wr ? 2'b11 : (wide ? ~v.be : {1'b1, ~v.be[0]});
    mux_en = v.en; req_valid = 1'b1; req_addr = v.addr; req_wdata = v.wd;
    req_write = v.wr; req_be = v.be; bus_in = v.din;
    @(negedge clk);
    req_valid = 1'b0;
    if (!v.en) begin
      check("R9 refused request", {25'd0, rsp_done, rsp_err, cs_n, adr_hold_n, rd_n, wr_n},
                                  {25'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11});
      return;
    end
    for (int i = 1; i <= 3; i++) begin
      check("R3 address strobes", {27'd0, cs_n, adr_hold_n, rd_n, wr_n},
                                  {27'd0, 1'b0, 1'b0, 1'b1, 2'b11});
      check("R4 address drive", {14'd0, bus_oe, bus_out & amask},
                                {14'd0, wide, 1'b1, v.addr & amask});
      if (poke && i == 2) begin
        req_valid = 1'b1; req_addr = 16'h5555;
      end
      if (poke && i == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    for (int i = 4; i <= 5; i++) begin
      check(v.wr ? (wide ? "R6 write strobes" : "R7 narrow write strobes") : "R5 read strobe",
            {27'd0, cs_n, adr_hold_n, rd_n, wr_n},
            {27'd0, 1'b0, 1'b1, v.wr, wexp});
      if (v.wr) begin
        dmask = amask;
        check(wide ? "R6 write drive" : "R7 narrow write drive",
              {14'd0, bus_oe, bus_out & dmask}, {14'd0, wide, 1'b1, v.wd & dmask});
      end else begin
        check("R5 bus released", {30'd0, bus_oe}, 32'd0);
      end
      @(negedge clk);
    end
    check("R8 completion", {29'd0, rsp_done, rsp_err, cs_n}, {29'd0, 1'b1, 1'b0, 1'b1});
    if (!v.wr) check("R5 read data", {16'd0, rsp_rdata}, {16'd0, v.exp_rd});
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; mux_en = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_wdata = '0; req_write = 1'b0; req_be = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    idle_pins("R1 pins in reset");
    check("R1 response in reset", {30'd0, rsp_done, rsp_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins("R1 pins after reset");

    // Table walked back to back: each request lands in the previous
    // completion cycle (R11).
    for (int k = 0; k < NVEC; k++) begin
      run(VECS[k], 1'b0);
    end
    @(negedge clk);
    check("R8 single-cycle done", {31'd0, rsp_done}, 32'd0);
    idle_pins("R2 idle after table");

    // R10: request raised mid-access is dropped.
    run(VECS[0], 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 mid-access request ignored", {31'd0, cs_n}, 32'd1);
    end

    // R11: explicit back-to-back, new address appears next cycle.
    run(VECS[1], 1'b0);
    mux_en = 1'b1; req_valid = 1'b1; req_addr = 16'h4321; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 chained address", {15'd0, cs_n, bus_out}, {15'd0, 1'b0, 16'h4321});
    repeat (5) @(negedge clk);

    // R1: reset in the middle of an access.
    req_valid = 1'b1; req_addr = 16'h4444; req_write = 1'b1; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 access started", {31'd0, cs_n}, 32'd0);
    rst_n = 1'b0;
    #1;
    idle_pins("R1 reset mid-access");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins("R1 idle after second reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule